// File: doc/BRIEF.md
# Private Interrupt Enable Clear Register

This block keeps, for one processor core, the forwarding-enable state of 32 private interrupts. Interrupt numbers 0 to 15 are software-generated and numbers 16 to 31 are per-peripheral. It drives the resulting 32-bit enable vector to the core's interrupt interface. Software reaches the state through a small memory-mapped port with two views of the same storage. Writing ones to the clear view turns forwarding off, and writing ones to the set view turns it on. A read of either view returns the current state.

Each bit is gated per access. An interrupt counts as secure when its group bit marks it secure and the global security-disable input is low; otherwise it counts as non-secure. If the routing mode for the interrupt's security state is off, its bit reads as zero and ignores writes. A non-secure access also cannot see or change secure interrupts while security-disable is low. A secure access reaches every bit and is limited only by routing. The register port is a plain strobe interface with no back-pressure. A write lands on the clock edge that samples its strobe. Read data comes back one cycle after the read strobe, with a valid flag.

Top module: `pirq_enable_regs`

## Requirements
- R1: After reset, `fwd_enable` is all zeros, `reg_rvalid` is 0 and `reg_rdata` is 0.
- R2: A write to the set view (offset 0x100) sets every accessible bit whose write-data bit is 1. Zero data bits leave their bits unchanged.
- R3: A write to the clear view (offset 0x180) clears every accessible bit whose write-data bit is 1. Zero data bits, and any inaccessible bit, keep their value.
- R4: A read strobe at one edge gives `reg_rvalid` = 1 after that edge. The data is the enable state before any write at that same edge, ANDed with the access mask. With no read strobe, `reg_rvalid` is 0 after the edge.
- R5: With `sec_disable` = 0, a non-secure access (`reg_nonsecure` = 1) reads 0 and has no write effect on every bit whose `grp_secure` bit is 1.
- R6: With `sec_disable` = 1, the group vector is ignored: every interrupt counts as non-secure, and a non-secure access reaches all bits that routing allows.
- R7: A secure access (`reg_nonsecure` = 0) reads and writes every bit regardless of its group, subject only to routing.
- R8: A secure interrupt (group bit 1 and `sec_disable` 0) is accessible only when `route_en_s` = 1. Every other interrupt is accessible only when `route_en_ns` = 1. An inaccessible bit reads 0 and ignores both set and clear writes.
- R9: A write to any offset other than 0x100 or 0x180 changes nothing. A read of such an offset returns 0 with `reg_rvalid` = 1.
- R10: With no write strobe, `fwd_enable` holds its value. After an accepted write, `fwd_enable` shows the new state from that clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Byte offset within the register frame |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data, one bit per interrupt number |
| reg_rd_en | input | 1 | Read strobe |
| reg_nonsecure | input | 1 | Access attribute: 1 = non-secure, 0 = secure |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| grp_secure | input | 32 | Per-interrupt group: 1 = secure group |
| sec_disable | input | 1 | Global security-disable control |
| route_en_s | input | 1 | Routing mode enabled for the secure state |
| route_en_ns | input | 1 | Routing mode enabled for the non-secure state |
| fwd_enable | output | 32 | Forwarding-enable vector to the core interface |

## Verification
The assertions assume that the group, security-disable and routing inputs are stable across the clock edge at which an access is sampled. They also assume the access attribute is valid whenever a strobe is high. The bench meets this by changing every input only on the falling clock edge and by holding the configuration for the whole of each access. Reads and writes are issued as separate accesses, so each read observes a state the bench model already holds.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned PIRQ_ADDR_W = 12;
  localparam int unsigned PIRQ_N_SGI  = 16;
  localparam int unsigned PIRQ_N_PPI  = 16;
  localparam int unsigned PIRQ_N      = PIRQ_N_SGI + PIRQ_N_PPI;

  localparam logic [PIRQ_ADDR_W-1:0] OFS_SET = 12'h100;
  localparam logic [PIRQ_ADDR_W-1:0] OFS_CLR = 12'h180;

  typedef enum logic [1:0] {
    VIEW_NONE = 2'd0,
    VIEW_SET  = 2'd1,
    VIEW_CLR  = 2'd2
  } view_e;

  function automatic view_e decode_view(input logic [PIRQ_ADDR_W-1:0] a);
    if (a == OFS_SET)      return VIEW_SET;
    else if (a == OFS_CLR) return VIEW_CLR;
    else                   return VIEW_NONE;
  endfunction
endpackage

// File: rtl/pirq_access_mask.sv
module pirq_access_mask #(
  parameter int unsigned N = pirq_pkg::PIRQ_N
) (
  input  logic [N-1:0] grp_secure,
  input  logic         sec_disable,
  input  logic         route_en_s,
  input  logic         route_en_ns,
  input  logic         nonsecure,
  output logic [N-1:0] mask
);
  // Per-interrupt gating: routing for its security state, then access security.
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic irq_is_secure;
    logic route_ok;
    logic sec_ok;
    assign irq_is_secure = grp_secure[i] & ~sec_disable;
    assign route_ok      = irq_is_secure ? route_en_s : route_en_ns;
    assign sec_ok        = ~(nonsecure & irq_is_secure);
    assign mask[i]       = route_ok & sec_ok;
  end
endmodule

// File: rtl/pirq_enable_store.sv
module pirq_enable_store #(
  parameter int unsigned N = pirq_pkg::PIRQ_N
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  pirq_pkg::view_e view,
  input  logic [N-1:0]   wdata,
  input  logic [N-1:0]   mask,
  output logic [N-1:0]   en_q
);
  logic [N-1:0] set_bits;
  logic [N-1:0] clr_bits;
  logic [N-1:0] en_d;

  always_comb begin
    set_bits = '0;
    clr_bits = '0;
    if (wr_en) begin
      if (view == pirq_pkg::VIEW_SET) set_bits = wdata & mask;
      if (view == pirq_pkg::VIEW_CLR) clr_bits = wdata & mask;
    end
    // Clear wins over set on the same bit.
    en_d = (en_q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/pirq_read_port.sv
module pirq_read_port #(
  parameter int unsigned N = pirq_pkg::PIRQ_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  pirq_pkg::view_e view,
  input  logic [N-1:0]    en_q,
  input  logic [N-1:0]    mask,
  output logic [N-1:0]    rdata,
  output logic            rvalid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= (view != pirq_pkg::VIEW_NONE) ? (en_q & mask) : '0;
    end
  end
endmodule

// File: rtl/pirq_enable_regs.sv
module pirq_enable_regs #(
  parameter int unsigned ADDR_W = pirq_pkg::PIRQ_ADDR_W,
  parameter int unsigned N      = pirq_pkg::PIRQ_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [N-1:0]      reg_wdata,
  input  logic              reg_rd_en,
  input  logic              reg_nonsecure,
  output logic [N-1:0]      reg_rdata,
  output logic              reg_rvalid,
  input  logic [N-1:0]      grp_secure,
  input  logic              sec_disable,
  input  logic              route_en_s,
  input  logic              route_en_ns,
  output logic [N-1:0]      fwd_enable
);
  pirq_pkg::view_e view;
  logic [N-1:0]    mask;

  assign view = pirq_pkg::decode_view(reg_addr);

  pirq_access_mask #(.N(N)) u_mask (
    .grp_secure (grp_secure),
    .sec_disable(sec_disable),
    .route_en_s (route_en_s),
    .route_en_ns(route_en_ns),
    .nonsecure  (reg_nonsecure),
    .mask       (mask)
  );

  pirq_enable_store #(.N(N)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(reg_wr_en),
    .view (view),
    .wdata(reg_wdata),
    .mask (mask),
    .en_q (fwd_enable)
  );

  pirq_read_port #(.N(N)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (reg_rd_en),
    .view  (view),
    .en_q  (fwd_enable),
    .mask  (mask),
    .rdata (reg_rdata),
    .rvalid(reg_rvalid)
  );
endmodule

// File: rtl/pirq_enable_regs_chk.sv
module pirq_enable_regs_chk #(
  parameter int unsigned ADDR_W = pirq_pkg::PIRQ_ADDR_W,
  parameter int unsigned N      = pirq_pkg::PIRQ_N
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic [N-1:0]      reg_wdata,
  input logic              reg_rd_en,
  input logic              reg_nonsecure,
  input logic [N-1:0]      reg_rdata,
  input logic              reg_rvalid,
  input logic [N-1:0]      grp_secure,
  input logic              sec_disable,
  input logic [N-1:0]      fwd_enable
);
  localparam logic [ADDR_W-1:0] A_SET = pirq_pkg::OFS_SET;
  localparam logic [ADDR_W-1:0] A_CLR = pirq_pkg::OFS_CLR;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (fwd_enable == '0 && !reg_rvalid));

  p_set_no_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == A_SET) |=> ((~fwd_enable & $past(fwd_enable)) == '0));

  p_clr_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == A_CLR) |=> ((fwd_enable & ~$past(fwd_enable)) == '0));

  p_clr_zero_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == A_CLR && reg_wdata == '0) |=> $stable(fwd_enable));

  p_rvalid_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rvalid);

  p_rvalid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> !reg_rvalid);

  p_ns_secure_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_nonsecure && !sec_disable)
      |=> (((fwd_enable ^ $past(fwd_enable)) & $past(grp_secure)) == '0));

  p_other_addr_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr != A_SET && reg_addr != A_CLR) |=> $stable(fwd_enable));

  p_other_addr_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr != A_SET && reg_addr != A_CLR) |=> (reg_rdata == '0));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(fwd_enable));
endmodule

bind pirq_enable_regs pirq_enable_regs_chk #(.ADDR_W(ADDR_W), .N(N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_addr     (reg_addr),
  .reg_wr_en    (reg_wr_en),
  .reg_wdata    (reg_wdata),
  .reg_rd_en    (reg_rd_en),
  .reg_nonsecure(reg_nonsecure),
  .reg_rdata    (reg_rdata),
  .reg_rvalid   (reg_rvalid),
  .grp_secure   (grp_secure),
  .sec_disable  (sec_disable),
  .fwd_enable   (fwd_enable)
);

// File: tb/pirq_enable_regs_test.sv
`timescale 1ns/1ps
module pirq_enable_regs_test;
  localparam logic [11:0] A_SET = 12'h100;
  localparam logic [11:0] A_CLR = 12'h180;
  localparam logic [11:0] A_BAD = 12'h040;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] reg_addr;
  logic        reg_wr_en, reg_rd_en, reg_nonsecure;
  logic [31:0] reg_wdata, reg_rdata, grp_secure, fwd_enable;
  logic        reg_rvalid, sec_disable, route_en_s, route_en_ns;

  int tests = 0;
  int fails = 0;
  logic [31:0] model_en;

  always #2 clk = ~clk;

  pirq_enable_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en), .reg_nonsecure(reg_nonsecure),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .grp_secure(grp_secure),
    .sec_disable(sec_disable), .route_en_s(route_en_s), .route_en_ns(route_en_ns),
    .fwd_enable(fwd_enable)
  );

  function automatic logic [31:0] f_mask(input logic ns, input logic [31:0] grp,
                                         input logic sd, input logic rs, input logic rns);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) begin
      logic s;
      s    = grp[i] && !sd;
      m[i] = (s ? rs : rns) && !(ns && s);
    end
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [31:0] grp, input logic sd, input logic rs, input logic rns);
    @(negedge clk);
    grp_secure = grp; sec_disable = sd; route_en_s = rs; route_en_ns = rns;
  endtask

  // One access; fwd_enable and read results are checked one cycle later.
  task automatic access(input string req, input logic wr, input logic [11:0] a,
                        input logic [31:0] d, input logic ns);
    logic [31:0] m, exp_rd;
    logic        rd;
    rd = !wr;
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_nonsecure = ns;
    reg_wr_en = wr; reg_rd_en = rd;
    m = f_mask(ns, grp_secure, sec_disable, route_en_s, route_en_ns);
    exp_rd = (a == A_SET || a == A_CLR) ? (model_en & m) : 32'h0;
    if (wr) begin
      if (a == A_SET) model_en = model_en | (d & m);
      if (a == A_CLR) model_en = model_en & ~(d & m);
    end
    @(negedge clk);
    reg_wr_en = 1'b0; reg_rd_en = 1'b0;
    chk({req, " fwd_enable"}, fwd_enable, model_en);
    chk({req, " rvalid"}, {31'b0, reg_rvalid}, {31'b0, rd});
    if (rd) chk({req, " rdata"}, reg_rdata, exp_rd);
  endtask

  initial begin
    #800000;
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wr_en = 1'b0; reg_rd_en = 1'b0;
    reg_nonsecure = 1'b0; grp_secure = 32'hFFFF_0000; sec_disable = 1'b0;
    route_en_s = 1'b1; route_en_ns = 1'b1; model_en = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset fwd_enable", fwd_enable, 32'h0);
    chk("R1 reset rvalid", {31'b0, reg_rvalid}, 32'h0);
    chk("R1 reset rdata", reg_rdata, 32'h0);

    access("R7 R2 secure set all", 1'b1, A_SET, 32'hFFFF_FFFF, 1'b0);
    chk("R2 literal", fwd_enable, 32'hFFFF_FFFF);
    access("R5 ns clear all", 1'b1, A_CLR, 32'hFFFF_FFFF, 1'b1);
    chk("R5 literal", fwd_enable, 32'hFFFF_0000);
    access("R5 ns read", 1'b0, A_CLR, 32'h0, 1'b1);
    access("R7 R4 secure read", 1'b0, A_SET, 32'h0, 1'b0);
    access("R3 clear zero data", 1'b1, A_CLR, 32'h0, 1'b0);
    cfg(32'hFFFF_0000, 1'b1, 1'b1, 1'b1);
    access("R6 ns read sd=1", 1'b0, A_CLR, 32'h0, 1'b1);
    access("R6 ns clear sd=1", 1'b1, A_CLR, 32'h00FF_0000, 1'b1);
    access("R3 secure clear part", 1'b1, A_CLR, 32'h0F00_0000, 1'b0);
    cfg(32'hFFFF_0000, 1'b0, 1'b1, 1'b0);
    access("R8 set route_ns off", 1'b1, A_SET, 32'hFFFF_FFFF, 1'b0);
    access("R8 read route_ns off", 1'b0, A_SET, 32'h0, 1'b0);
    cfg(32'hFFFF_0000, 1'b0, 1'b0, 1'b1);
    access("R8 clear route_s off", 1'b1, A_CLR, 32'hFFFF_FFFF, 1'b0);
    access("R9 bad addr write", 1'b1, A_BAD, 32'hFFFF_FFFF, 1'b0);
    access("R9 bad addr read", 1'b0, A_BAD, 32'h0, 1'b0);

    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [1:0]  sel;
      string       tag;
      if (n == 0) void'($urandom(32'h5EED_1234));
      if (n % 8 == 0)
        cfg($urandom, $urandom_range(0, 1), $urandom_range(0, 3) != 0,
            $urandom_range(0, 3) != 0);
      sel = 2'($urandom_range(0, 3));
      a   = (sel == 0) ? A_BAD : (sel == 1) ? A_SET : A_CLR;
      tag = (sel == 0) ? "R9 random" : (sel == 1) ? "R2 R10 random" : "R3 R5 R8 random";
      access(tag, $urandom_range(0, 1) == 1, a, $urandom, $urandom_range(0, 1) == 1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule